// File: doc/BRIEF.md
# Grayscale PWM Display Period Controller

This block produces the display timing for a multi-channel PWM LED driver. A period counter advances on every grayscale clock edge. Each channel output is on while the count is below that channel's grayscale value. One display period spans 2^GS_W clocks, which is 65,536 clocks at the default width. A one-cycle end-of-period strobe marks the last count of every period. The data latch logic uses it to swap in fresh grayscale values.

A period starts in one of two ways. The first is the blank control falling from 1 to 0. The second is a latch strobe tagged as a grayscale write while timing reset is enabled. That strobe also clears the counter and forces every output off for one clock. When the repeat enable is set, a new period follows each finished one with no gap. When it is clear, only one period runs and the outputs then stay off. Raising blank forces all outputs off in the same cycle and stops the period. Every control input is synchronous to the grayscale clock.

Top module: `gsp_disp_ctrl`

## Requirements
- R1: After reset every output is off and no end strobe is given until a start condition occurs. A blank input that is low during reset does not count as a start.
- R2: On the clock edge where blank is seen at 0 after being 1 the previous cycle, a period starts with count 0. The count then rises by one per clock through 2^GS_W-1, so one period lasts 2^GS_W clocks.
- R3: While a period runs, channel c (value at bits c*GS_W upward of gs_val_i) is on exactly when the count is below its value. A value of 0 keeps it off for the whole period, and the maximum value leaves it off only on the last count.
- R4: period_end_o is high for exactly the one cycle in which a running period holds the count 2^GS_W-1.
- R5: With repeat_en_i at 1 on the final count, the next period begins at count 0 on the following clock, with no idle cycle between periods.
- R6: With repeat_en_i at 0 on the final count, the block goes idle after that period. All outputs stay off and no end strobe occurs until the next start condition. repeat_en_i only matters on the final count.
- R7: While blank_i is 1, all channel outputs and period_end_o are 0 in that same cycle, and the counter is held at 0.
- R8: With tmg_rst_en_i at 1 and blank_i at 0, a clock edge that sees lat_strobe_i and lat_gs_i both at 1 sets the count to 0 and forces all outputs off for the next cycle. The count then stays at 0 for one more cycle so that a full period follows. This works both mid-period and from idle.
- R9: A latch strobe has no effect on the count or the outputs when tmg_rst_en_i is 0 or lat_gs_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Grayscale clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| blank_i | input | 1 | Blank control; 1 forces outputs off, a 1-to-0 change starts a period |
| repeat_en_i | input | 1 | Automatic period repeat enable |
| tmg_rst_en_i | input | 1 | Enables timing reset from a grayscale latch strobe |
| lat_strobe_i | input | 1 | Latch strobe, one cycle per load |
| lat_gs_i | input | 1 | Marks the current latch strobe as a grayscale write |
| gs_val_i | input | CH*GS_W | Active grayscale values, channel c at bits c*GS_W upward |
| chan_on_o | output | CH | Per-channel PWM on/off |
| period_end_o | output | 1 | One-cycle strobe on the final count of a period |

## Verification
Channel outputs and the end strobe are combinational on the registered count, so an effect is due one edge after its cause. A start or timing-reset edge shows up right after that edge. The first count-0 cycle follows a blank fall at once, and follows a timing reset one cycle later. Raising blank acts within the same cycle, with no edge in between. The bench drives inputs 2 ns after each rising edge and samples at that same point. The only exception is a blank-on check, made 1 ns after the change. Expected patterns come from the count index k that the bench tracks itself from the known start edge.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

   typedef struct packed {
      logic blank;
      logic repeat_en;
      logic tmg_rst_en;
   } gsp_ctrl_t;

   function automatic int unsigned gsp_period_len(input int unsigned width);
      return 32'd1 << width;
   endfunction

endpackage

// File: rtl/gsp_period_ctr.sv
module gsp_period_ctr
   import gsp_pkg::*;
#(
   parameter int unsigned GS_W = 16
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  gsp_ctrl_t       ctrl_i,
   input  logic            lat_strobe_i,
   input  logic            lat_gs_i,
   output logic [GS_W-1:0] cnt_o,
   output logic            run_o,
   output logic            period_end_o
);

   localparam logic [GS_W-1:0] CNT_MAX = {GS_W{1'b1}};

   logic [GS_W-1:0] cnt_q;
   logic            active_q;
   logic            hold_q;
   logic            blank_q;
   logic            tmg_hit;
   logic            blank_fall;

   assign tmg_hit    = lat_strobe_i & lat_gs_i & ctrl_i.tmg_rst_en;
   assign blank_fall = blank_q & ~ctrl_i.blank;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         hold_q   <= 1'b0;
         blank_q  <= 1'b0;
      end else begin
         blank_q <= ctrl_i.blank;
         hold_q  <= 1'b0;
         if (ctrl_i.blank) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
         end else if (tmg_hit) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
            hold_q   <= 1'b1;
         end else if (blank_fall) begin
            cnt_q    <= '0;
            active_q <= 1'b1;
         end else if (active_q && !hold_q) begin
            if (cnt_q == CNT_MAX) begin
               cnt_q    <= '0;
               active_q <= ctrl_i.repeat_en;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o        = cnt_q;
   assign run_o        = active_q & ~hold_q & ~ctrl_i.blank;
   assign period_end_o = run_o & (cnt_q == CNT_MAX);

endmodule

// File: rtl/gsp_chan_cmp.sv
module gsp_chan_cmp #(
   parameter int unsigned CH   = 16,
   parameter int unsigned GS_W = 16
) (
   input  logic [GS_W-1:0]    cnt_i,
   input  logic               run_i,
   input  logic [CH*GS_W-1:0] gs_val_i,
   output logic [CH-1:0]      on_o
);

   for (genvar c = 0; c < CH; c++) begin : g_ch
      logic [GS_W-1:0] level;
      assign level   = gs_val_i[c*GS_W +: GS_W];
      assign on_o[c] = run_i && (cnt_i < level);
   end

endmodule

// File: rtl/gsp_disp_ctrl.sv
module gsp_disp_ctrl
   import gsp_pkg::*;
#(
   parameter int unsigned CH   = 16,
   parameter int unsigned GS_W = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               blank_i,
   input  logic               repeat_en_i,
   input  logic               tmg_rst_en_i,
   input  logic               lat_strobe_i,
   input  logic               lat_gs_i,
   input  logic [CH*GS_W-1:0] gs_val_i,
   output logic [CH-1:0]      chan_on_o,
   output logic               period_end_o
);

   localparam int unsigned PERIOD_LEN = gsp_period_len(GS_W);

   if (GS_W < 2 || GS_W > 16) begin : g_bad_width
      $error("gsp_disp_ctrl: GS_W must lie in 2..16");
   end
   if (CH < 1 || CH > 64) begin : g_bad_ch
      $error("gsp_disp_ctrl: CH must lie in 1..64");
   end
   if (PERIOD_LEN < 4) begin : g_bad_len
      $error("gsp_disp_ctrl: period too short");
   end

   gsp_ctrl_t       ctrl;
   logic [GS_W-1:0] cnt_w;
   logic            run_w;

   assign ctrl = '{blank: blank_i, repeat_en: repeat_en_i, tmg_rst_en: tmg_rst_en_i};

   gsp_period_ctr #(.GS_W(GS_W)) ctr_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_i       (ctrl),
      .lat_strobe_i (lat_strobe_i),
      .lat_gs_i     (lat_gs_i),
      .cnt_o        (cnt_w),
      .run_o        (run_w),
      .period_end_o (period_end_o)
   );

   gsp_chan_cmp #(.CH(CH), .GS_W(GS_W)) cmp_i (
      .cnt_i    (cnt_w),
      .run_i    (run_w),
      .gs_val_i (gs_val_i),
      .on_o     (chan_on_o)
   );

endmodule

// File: rtl/gsp_disp_chk.sv
module gsp_disp_chk #(
   parameter int unsigned CH   = 16,
   parameter int unsigned GS_W = 16
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               blank_i,
   input logic               repeat_en_i,
   input logic               tmg_rst_en_i,
   input logic               lat_strobe_i,
   input logic               lat_gs_i,
   input logic [CH*GS_W-1:0] gs_val_i,
   input logic [CH-1:0]      chan_on_o,
   input logic               period_end_o,
   input logic [GS_W-1:0]    cnt_w,
   input logic               run_w
);

   localparam logic [GS_W-1:0] CMAX = {GS_W{1'b1}};

   logic tmg_hit;
   assign tmg_hit = lat_strobe_i & lat_gs_i & tmg_rst_en_i;

   // R7
   blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blank_i |-> (chan_on_o == '0 && !period_end_o));

   // R4
   end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_end_o |=> !period_end_o);

   // R8
   tmg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmg_hit && !blank_i) |=> (chan_on_o == '0 && cnt_w == '0));

   // R9
   lat_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_strobe_i && !tmg_hit && run_w && cnt_w != CMAX)
      |=> cnt_w == GS_W'($past(cnt_w) + 1'b1));

   // R6
   oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_end_o && !repeat_en_i && !tmg_hit) |=> (!run_w && chan_on_o == '0));

   // R3
   zero_gs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gs_val_i[GS_W-1:0] == '0) |-> !chan_on_o[0]);

endmodule

bind gsp_disp_ctrl gsp_disp_chk #(.CH(CH), .GS_W(GS_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .blank_i      (blank_i),
   .repeat_en_i  (repeat_en_i),
   .tmg_rst_en_i (tmg_rst_en_i),
   .lat_strobe_i (lat_strobe_i),
   .lat_gs_i     (lat_gs_i),
   .gs_val_i     (gs_val_i),
   .chan_on_o    (chan_on_o),
   .period_end_o (period_end_o),
   .cnt_w        (cnt_w),
   .run_w        (run_w)
);

// File: tb/gsp_disp_ctrl_tb.sv
`timescale 1ns/1ps
module gsp_disp_ctrl_tb_top;

   localparam int CH   = 4;
   localparam int W    = 4;
   localparam int PER  = 1 << W;
   localparam int MAXC = PER - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            blank = 1'b1;
   logic            rpt = 1'b0;
   logic            tren = 1'b0;
   logic            lat = 1'b0;
   logic            latgs = 1'b0;
   logic [CH*W-1:0] gs = '0;
   logic [CH-1:0]   on;
   logic            pend;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   gsp_disp_ctrl #(.CH(CH), .GS_W(W)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .blank_i      (blank),
      .repeat_en_i  (rpt),
      .tmg_rst_en_i (tren),
      .lat_strobe_i (lat),
      .lat_gs_i     (latgs),
      .gs_val_i     (gs),
      .chan_on_o    (on),
      .period_end_o (pend)
   );

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic expect_k(input int k, input string req);
      logic [CH-1:0] e;
      for (int i = 0; i < CH; i++) e[i] = (k < int'(gs[i*W +: W]));
      chk({req, " chan"}, int'(on), int'(e));
      chk({req, " end"}, int'(pend), (k == MAXC) ? 1 : 0);
   endtask

   task automatic expect_off(input string req);
      chk({req, " chan off"}, int'(on), 0);
      chk({req, " no end"}, int'(pend), 0);
   endtask

   task automatic start_by_blank();
      blank = 1'b1;
      cyc();
      blank = 1'b0;
   endtask

   task automatic t_reset();
      blank = 1'b0;
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      for (int n = 0; n < 6; n++) begin
         cyc();
         expect_off("R1");
      end
   endtask

   task automatic t_oneshot();
      gs = {4'd15, 4'd5, 4'd1, 4'd0};
      rpt = 1'b0;
      start_by_blank();
      for (int k = 0; k < PER; k++) begin
         cyc();
         expect_k(k, (k == MAXC) ? "R4" : ((k < 2) ? "R2" : "R3"));
      end
      for (int n = 0; n < 20; n++) begin
         cyc();
         expect_off("R6");
      end
   endtask

   task automatic t_repeat();
      gs = {4'd8, 4'd15, 4'd0, 4'd3};
      rpt = 1'b1;
      start_by_blank();
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < PER; k++) begin
            cyc();
            expect_k(k, "R5");
         end
      end
      for (int k = 0; k < 5; k++) begin
         cyc();
         expect_k(k, "R5");
      end
      blank = 1'b1;
      #1;
      expect_off("R7 same cycle");
      for (int n = 0; n < 20; n++) begin
         cyc();
         expect_off("R7 held");
      end
   endtask

   task automatic t_tmgrst();
      gs = {4'd3, 4'd12, 4'd15, 4'd8};
      tren = 1'b1;
      rpt = 1'b1;
      start_by_blank();
      for (int k = 0; k < 7; k++) begin
         cyc();
         expect_k(k, "R8 pre");
      end
      lat = 1'b1;
      latgs = 1'b1;
      cyc();
      lat = 1'b0;
      latgs = 1'b0;
      expect_off("R8 forced");
      for (int k = 0; k < PER; k++) begin
         cyc();
         expect_k(k, "R8 restart");
         if (k == 10) rpt = 1'b0;
      end
      for (int n = 0; n < 10; n++) begin
         cyc();
         expect_off("R6 late clear");
      end
      lat = 1'b1;
      latgs = 1'b1;
      cyc();
      lat = 1'b0;
      latgs = 1'b0;
      expect_off("R8 idle forced");
      for (int k = 0; k < PER; k++) begin
         cyc();
         expect_k(k, "R8 idle start");
      end
      cyc();
      expect_off("R6 after");
   endtask

   task automatic t_lat_ignored();
      gs = {4'd2, 4'd9, 4'd6, 4'd14};
      tren = 1'b0;
      rpt = 1'b1;
      start_by_blank();
      for (int k = 0; k < PER; k++) begin
         if (k == 5) begin
            lat = 1'b1;
            latgs = 1'b1;
         end
         cyc();
         lat = 1'b0;
         latgs = 1'b0;
         expect_k(k, "R9 disabled");
      end
      tren = 1'b1;
      for (int k = 0; k < PER; k++) begin
         if (k == 4) lat = 1'b1;
         cyc();
         lat = 1'b0;
         expect_k(k, "R9 untagged");
      end
      blank = 1'b1;
      cyc();
      expect_off("R7 end");
   endtask

   initial begin
      t_reset();
      t_oneshot();
      t_repeat();
      t_tmgrst();
      t_lat_ignored();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule